// File: doc/BRIEF.md
# FIFO-Drain DMA Channel with Stall Address Publication

This block is a single normal-mode DMA channel that empties a producer's output FIFO into memory, one 128-bit quadword per cycle. Software loads a start address and a quadword count, then starts the channel. Whenever the channel is running, it checks how many quadwords the FIFO holds. It then moves a burst of the smaller of that occupancy and the remaining count. Each quadword it writes advances the address by 16 bytes and lowers the count by one. When the count reaches zero, the channel stops and raises a done interrupt. That interrupt stays pending until it is acknowledged.

While a system-level select marks this channel as the stall source, the channel copies its updated write address into a stall address register at the end of every burst. A destination select then picks no consumer or one of three consumers, and the chosen consumer's stall flag is set. Each flag is cleared by a per-destination clear input when that consumer is serviced. The channel also guards its start. If the count word has any bits set above the count field, the word is wiped and the channel completes with an interrupt. A start with a zero count finishes at once. A start that requests tag transfer is refused.

Top module: `fifo_drain_dma`

## Requirements
- R1: After reset the channel is idle, the address, count word and stall address are zero, no stall flag is set, the done interrupt is low, and no FIFO read or memory write is issued.
- R2: While the channel is running and the FIFO occupancy is zero, no quadword moves and the address and count hold. The channel keeps polling and starts a burst once data appears.
- R3: A burst starts one cycle after the channel sees a nonzero occupancy. It moves min(remaining count, occupancy) quadwords on consecutive cycles. Each quadword pops the FIFO and writes the FIFO data at the current address. The address then increases by 16 and the count decreases by 1.
- R4: When a burst ends and the stall-source select is 1, the stall address takes the address as updated by that burst. When the select is 0, the stall address is unchanged.
- R5: At the end of a burst, a destination select of 1, 2 or 3 sets stall flag bit 0, 1 or 2 respectively, and a select of 0 sets none. A clear bit resets its flag, and a set in the same cycle wins over a clear.
- R6: When a burst brings the count to zero, busy drops and the done interrupt rises in the same cycle. The interrupt stays high until the acknowledge input is pulsed.
- R7: The count word is 32 bits: the count is bits 15:0 and bits 31:16 must be zero. If bits 31:16 are nonzero at start, the whole word is cleared, no quadword moves, the channel stays idle, and the done interrupt rises.
- R8: A start with a count of zero and clean upper bits moves nothing, leaves the channel idle, and raises the done interrupt on the next cycle.
- R9: While the done interrupt is pending, a running channel starts no new burst. Bursts resume once the interrupt is acknowledged.
- R10: A start issued with the tag-transfer request high is ignored. The channel stays idle and no interrupt is raised.
- R11: Writes to the address and count registers are accepted only while the channel is idle. Writes while it is busy leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_madr_wr | input | 1 | Write strobe for the address register |
| cfg_madr_val | input | 32 | Value for the address register |
| cfg_qwc_wr | input | 1 | Write strobe for the count word |
| cfg_qwc_val | input | 32 | Count word: count in 15:0, must-be-zero in 31:16 |
| start | input | 1 | Start pulse |
| tag_opt | input | 1 | Tag-transfer request accompanying start (unsupported) |
| madr_q | output | 32 | Current write address |
| qwc_q | output | 32 | Current count word |
| busy | output | 1 | Channel running |
| fifo_count | input | 4 | Producer FIFO occupancy in quadwords |
| fifo_data | input | 128 | Head quadword of the FIFO |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 128 | Memory write data |
| stall_src_sel | input | 1 | This channel is the stall source |
| stall_dst_sel | input | 2 | Stall destination: 0 none, 1..3 consumer |
| stall_clr | input | 3 | Per-destination stall flag clear |
| stall_addr | output | 32 | Published stall address |
| stall_flag | output | 3 | Per-destination stall flags |
| irq_ack | input | 1 | Done interrupt acknowledge |
| done_irq | output | 1 | Done interrupt, pending until acknowledged |

## Verification
The stimulus lets the FIFO run dry in the middle of a transfer. A channel that treated an empty FIFO as a burst of zero would stall forever, and one that ignored occupancy would write stale data. A partly filled FIFO with a smaller remaining count checks the minimum rule. Getting that wrong would overrun the count or leave quadwords behind. A start is issued while an old interrupt is still pending, which catches a channel that pushes data before software has seen the last completion. Dirty upper count bits, a zero count and a tag-transfer start each test one start guard. The bench also flips the source and destination selects between bursts, which exposes a stall address or flag that updates when the channel is not the source, or that lands on the wrong consumer.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_POLL = 2'd1,
    PH_MOVE = 2'd2,
    PH_WRAP = 2'd3
  } fdma_phase_e;

  localparam int unsigned QW_BYTES = 16;

  // Quadwords in the next burst: smaller of what is owed and what is queued.
  function automatic logic [31:0] burst_len(input logic [31:0] owed,
                                            input logic [31:0] queued);
    return (owed < queued) ? owed : queued;
  endfunction

  // Address of the quadword following a.
  function automatic logic [31:0] step_addr(input logic [31:0] a);
    return a + 32'(QW_BYTES);
  endfunction

endpackage

// File: rtl/fdma_ctl.sv
module fdma_ctl
  import fdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned QW = 16,
  parameter int unsigned HW = 16,
  parameter int unsigned CW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_madr_wr,
  input  logic [AW-1:0]    cfg_madr_val,
  input  logic             cfg_qwc_wr,
  input  logic [QW+HW-1:0] cfg_qwc_val,
  input  logic             start,
  input  logic             tag_opt,
  input  logic [CW-1:0]    fifo_count,
  input  logic             irq_ack,
  output logic [AW-1:0]    madr,
  output logic [QW+HW-1:0] qwc_word,
  output logic             busy,
  output logic             xfer,
  output logic             burst_end,
  output logic             done_evt,
  output logic             done_irq
);

  localparam int unsigned CTW = QW + HW;

  fdma_phase_e      ph_q;
  logic [QW-1:0]    rem_q;
  logic [QW-1:0]    qwc_lo;
  logic [HW-1:0]    qwc_hi;
  logic             start_ok;
  logic             bad_hi;
  logic             zero_cnt;
  logic             can_burst;
  logic             last_beat;

  assign qwc_lo    = qwc_word[QW-1:0];
  assign qwc_hi    = qwc_word[CTW-1:QW];
  assign start_ok  = start && !tag_opt && (ph_q == PH_IDLE);
  assign bad_hi    = (qwc_hi != '0);
  assign zero_cnt  = (qwc_lo == '0);
  assign can_burst = (ph_q == PH_POLL) && !done_irq && (fifo_count != '0);
  assign last_beat = (rem_q == QW'(1));

  assign busy      = (ph_q != PH_IDLE);
  assign xfer      = (ph_q == PH_MOVE);
  assign burst_end = (ph_q == PH_WRAP);
  assign done_evt  = (burst_end && zero_cnt) || (start_ok && (bad_hi || zero_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      madr     <= '0;
      qwc_word <= '0;
      rem_q    <= '0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= (done_irq && !irq_ack) || done_evt;
      unique case (ph_q)
        PH_IDLE: begin
          if (cfg_madr_wr) madr <= cfg_madr_val;
          if (cfg_qwc_wr)  qwc_word <= cfg_qwc_val;
          if (start_ok) begin
            if (bad_hi)         qwc_word <= '0;
            else if (!zero_cnt) ph_q <= PH_POLL;
          end
        end
        PH_POLL: begin
          if (can_burst) begin
            rem_q <= QW'(burst_len(32'(qwc_lo), 32'(fifo_count)));
            ph_q  <= PH_MOVE;
          end
        end
        PH_MOVE: begin
          madr     <= AW'(step_addr(32'(madr)));
          qwc_word <= {qwc_hi, qwc_lo - QW'(1)};
          rem_q    <= rem_q - QW'(1);
          if (last_beat) ph_q <= PH_WRAP;
        end
        PH_WRAP: begin
          ph_q <= zero_cnt ? PH_IDLE : PH_POLL;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fdma_wport.sv
module fdma_wport #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 128
) (
  input  logic          xfer,
  input  logic [AW-1:0] madr,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  // Head of FIFO goes straight to memory; pop and write share one strobe.
  assign fifo_rd   = xfer;
  assign mem_we    = xfer;
  assign mem_addr  = xfer ? madr : '0;
  assign mem_wdata = xfer ? fifo_data : '0;

endmodule

// File: rtl/fdma_stall.sv
module fdma_stall #(
  parameter int unsigned AW    = 32,
  parameter int unsigned NDEST = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       burst_end,
  input  logic [AW-1:0]              madr,
  input  logic                       src_sel,
  input  logic [$clog2(NDEST+1)-1:0] dst_sel,
  input  logic [NDEST-1:0]           clr,
  output logic [AW-1:0]              stall_addr,
  output logic [NDEST-1:0]           flag
);

  localparam int unsigned DSW = $clog2(NDEST + 1);

  logic publish;
  assign publish = burst_end && src_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       stall_addr <= '0;
    else if (publish) stall_addr <= madr;
  end

  for (genvar d = 0; d < NDEST; d++) begin : g_dest
    logic hit;
    assign hit = publish && (dst_sel == DSW'(d + 1));
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[d] <= 1'b0;
      else if (hit)    flag[d] <= 1'b1;
      else if (clr[d]) flag[d] <= 1'b0;
    end
  end

endmodule

// File: rtl/fifo_drain_dma.sv
module fifo_drain_dma
  import fdma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 128,
  parameter int unsigned QW    = 16,
  parameter int unsigned HW    = 16,
  parameter int unsigned CW    = 4,
  parameter int unsigned NDEST = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_madr_wr,
  input  logic [AW-1:0]              cfg_madr_val,
  input  logic                       cfg_qwc_wr,
  input  logic [QW+HW-1:0]           cfg_qwc_val,
  input  logic                       start,
  input  logic                       tag_opt,
  output logic [AW-1:0]              madr_q,
  output logic [QW+HW-1:0]           qwc_q,
  output logic                       busy,
  input  logic [CW-1:0]              fifo_count,
  input  logic [DW-1:0]              fifo_data,
  output logic                       fifo_rd,
  output logic                       mem_we,
  output logic [AW-1:0]              mem_addr,
  output logic [DW-1:0]              mem_wdata,
  input  logic                       stall_src_sel,
  input  logic [$clog2(NDEST+1)-1:0] stall_dst_sel,
  input  logic [NDEST-1:0]           stall_clr,
  output logic [AW-1:0]              stall_addr,
  output logic [NDEST-1:0]           stall_flag,
  input  logic                       irq_ack,
  output logic                       done_irq
);

  logic xfer;
  logic burst_end;
  logic done_evt;

  fdma_ctl #(.AW(AW), .QW(QW), .HW(HW), .CW(CW)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_madr_wr (cfg_madr_wr),
    .cfg_madr_val(cfg_madr_val),
    .cfg_qwc_wr  (cfg_qwc_wr),
    .cfg_qwc_val (cfg_qwc_val),
    .start       (start),
    .tag_opt     (tag_opt),
    .fifo_count  (fifo_count),
    .irq_ack     (irq_ack),
    .madr        (madr_q),
    .qwc_word    (qwc_q),
    .busy        (busy),
    .xfer        (xfer),
    .burst_end   (burst_end),
    .done_evt    (done_evt),
    .done_irq    (done_irq)
  );

  fdma_wport #(.AW(AW), .DW(DW)) u_wport (
    .xfer     (xfer),
    .madr     (madr_q),
    .fifo_data(fifo_data),
    .fifo_rd  (fifo_rd),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  fdma_stall #(.AW(AW), .NDEST(NDEST)) u_stall (
    .clk       (clk),
    .rst_n     (rst_n),
    .burst_end (burst_end),
    .madr      (madr_q),
    .src_sel   (stall_src_sel),
    .dst_sel   (stall_dst_sel),
    .clr       (stall_clr),
    .stall_addr(stall_addr),
    .flag      (stall_flag)
  );

endmodule

// File: rtl/fdma_chk.sv
module fdma_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned QW    = 16,
  parameter int unsigned CW    = 4,
  parameter int unsigned NDEST = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_we,
  input logic             busy,
  input logic [AW-1:0]    madr_q,
  input logic [QW-1:0]    qwc_lo,
  input logic [CW-1:0]    fifo_count,
  input logic             done_irq,
  input logic             done_evt,
  input logic             stall_src_sel,
  input logic [AW-1:0]    stall_addr,
  input logic [NDEST-1:0] stall_flag
);

  // R3: a quadword is only written while the FIFO holds one
  a_r3_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (fifo_count != '0));

  // R3: each written quadword advances the address by 16
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (madr_q == $past(madr_q) + AW'(16)));

  // R3: each written quadword lowers the count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (qwc_lo == $past(qwc_lo) - QW'(1)));

  // R2: an empty FIFO while polling starts nothing
  a_r2_wait_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we && fifo_count == '0) |=> !mem_we);

  // R4: stall address holds while not the stall source
  a_r4_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_src_sel |=> $stable(stall_addr));

  // R5: at most one destination flag is newly set per cycle
  a_r5_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $onehot0(stall_flag & ~$past(stall_flag)));

  // R6: stopping coincides with a raised done interrupt
  a_r6_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);

  // R6: a completion event always leaves the interrupt pending
  a_r6_evt_irq: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_irq);

  // R9: a pending interrupt blocks a new burst
  a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !mem_we) |=> !mem_we);

  // R6: memory writes only happen while running
  a_r6_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

endmodule

bind fifo_drain_dma fdma_chk #(.AW(AW), .QW(QW), .CW(CW), .NDEST(NDEST)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_we       (mem_we),
  .busy         (busy),
  .madr_q       (madr_q),
  .qwc_lo       (qwc_q[QW-1:0]),
  .fifo_count   (fifo_count),
  .done_irq     (done_irq),
  .done_evt     (done_evt),
  .stall_src_sel(stall_src_sel),
  .stall_addr   (stall_addr),
  .stall_flag   (stall_flag)
);

// File: tb/tb_fifo_drain_dma.sv
module tb_fifo_drain_dma;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_madr_wr = 1'b0;
  logic [31:0]  cfg_madr_val = '0;
  logic         cfg_qwc_wr = 1'b0;
  logic [31:0]  cfg_qwc_val = '0;
  logic         start = 1'b0;
  logic         tag_opt = 1'b0;
  logic [31:0]  madr_q;
  logic [31:0]  qwc_q;
  logic         busy;
  logic [3:0]   fifo_count = '0;
  logic [127:0] fifo_data = '0;
  logic         fifo_rd;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         stall_src_sel = 1'b0;
  logic [1:0]   stall_dst_sel = '0;
  logic [2:0]   stall_clr = '0;
  logic [31:0]  stall_addr;
  logic [2:0]   stall_flag;
  logic         irq_ack = 1'b0;
  logic         done_irq;

  always #10 clk = ~clk;

  fifo_drain_dma dut (.*);

  // requested inputs, applied at the next falling edge
  logic         q_madr_wr = 0, q_qwc_wr = 0, q_start = 0, q_tag = 0, q_ack = 0;
  logic [31:0]  q_madr_val = 0, q_qwc_val = 0;
  logic [2:0]   q_clr = 0;
  logic         q_src = 0;
  logic [1:0]   q_dst = 0;

  logic [127:0] fifo_q[$];
  int unsigned  push_id = 0;

  // behavioural reference
  int           m_phase;      // 0 idle, 1 waiting for data, 2 moving, 3 burst closing
  logic [31:0]  m_addr, m_word, m_saddr;
  int           m_left;
  bit           m_irq;
  logic [2:0]   m_flag;

  int           tests = 0, fails = 0, cycles = 0;
  bit           finished = 0;

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] old_word;
    int          owed, queued;
    bit          fin;
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      wrap_up();
    end
    cfg_madr_wr = q_madr_wr; cfg_madr_val = q_madr_val;
    cfg_qwc_wr = q_qwc_wr; cfg_qwc_val = q_qwc_val;
    start = q_start; tag_opt = q_tag; irq_ack = q_ack; stall_clr = q_clr;
    stall_src_sel = q_src; stall_dst_sel = q_dst;
    q_madr_wr = 0; q_qwc_wr = 0; q_start = 0; q_ack = 0; q_clr = 0;
    fifo_count = 4'(fifo_q.size());
    fifo_data = (fifo_q.size() > 0) ? fifo_q[0] : '0;
    #1;
    if (!rst_n) begin
      m_phase = 0; m_addr = 0; m_word = 0; m_saddr = 0; m_left = 0; m_irq = 0; m_flag = 0;
    end else begin
      check("R3", "fifo_rd", fifo_rd, m_phase == 2);
      check("R3", "mem_we", mem_we, m_phase == 2);
      if (m_phase == 2) begin
        check("R3", "mem_addr", mem_addr, m_addr);
        check("R3", "mem_wdata", mem_wdata, fifo_q[0]);
      end
      check("R3", "madr", madr_q, m_addr);
      check("R3", "qwc word", qwc_q, m_word);
      check("R6", "busy", busy, m_phase != 0);
      check("R6", "done_irq", done_irq, m_irq);
      check("R4", "stall_addr", stall_addr, m_saddr);
      check("R5", "stall_flag", stall_flag, m_flag);
      // advance the reference by one clock
      fin = 0;
      old_word = m_word;
      m_flag = m_flag & ~stall_clr;
      case (m_phase)
        0: begin
          if (cfg_madr_wr) m_addr = cfg_madr_val;
          if (cfg_qwc_wr)  m_word = cfg_qwc_val;
          if (start && !tag_opt) begin
            if (old_word[31:16] != 0) begin m_word = 0; fin = 1; end
            else if (old_word[15:0] == 0) fin = 1;
            else m_phase = 1;
          end
        end
        1: begin
          owed = m_word[15:0]; queued = fifo_q.size();
          if (!m_irq && queued > 0) begin
            m_left = (owed < queued) ? owed : queued;
            m_phase = 2;
          end
        end
        2: begin
          void'(fifo_q.pop_front());
          m_addr += 16; m_word -= 1; m_left--;
          if (m_left == 0) m_phase = 3;
        end
        default: begin
          if (stall_src_sel) begin
            m_saddr = m_addr;
            if (stall_dst_sel != 0) m_flag[stall_dst_sel - 1] = 1'b1;
          end
          if (m_word[15:0] == 0) begin m_phase = 0; fin = 1; end
          else m_phase = 1;
        end
      endcase
      m_irq = (m_irq && !irq_ack) || fin;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      push_id++;
      fifo_q.push_back({32'hC0DE0000 + push_id, push_id, ~push_id, 32'(push_id * 7)});
    end
  endtask

  task automatic setup(input logic [31:0] a, input logic [31:0] w);
    @(posedge clk); q_madr_wr = 1; q_madr_val = a; q_qwc_wr = 1; q_qwc_val = w;
    @(posedge clk);
  endtask

  task automatic go(input bit tag);
    @(posedge clk); q_start = 1; q_tag = tag;
    @(posedge clk); q_tag = 0;
  endtask

  task automatic ack();
    @(posedge clk); q_ack = 1;
    @(posedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(posedge clk);
    tick(1);
  endtask

  initial begin
    tick(4);
    #5;
    check("R1", "reset busy", busy, 0);
    check("R1", "reset madr", madr_q, 0);
    check("R1", "reset qwc", qwc_q, 0);
    check("R1", "reset irq", done_irq, 0);
    check("R1", "reset flags", stall_flag, 0);
    check("R1", "reset stall addr", stall_addr, 0);
    check("R1", "reset mem_we", mem_we, 0);
    @(posedge clk); rst_n = 1;
    tick(2);

    // partial FIFO, then starvation, then a larger FIFO than owed (R2, R3)
    q_src = 1; q_dst = 2;
    setup(32'h1000, 32'd5);
    push(3);
    go(0);
    tick(15);
    #5;
    check("R2", "count held when FIFO dry", qwc_q, 32'd2);
    check("R2", "still busy when FIFO dry", busy, 1);
    check("R4", "stall addr after first burst", stall_addr, 32'h1030);
    q_dst = 3;
    push(4);
    wait_idle();
    #5;
    check("R3", "final address", madr_q, 32'h1050);
    check("R3", "leftover FIFO entries", fifo_q.size(), 2);
    check("R5", "flags of both bursts", stall_flag, 3'b110);
    check("R6", "irq after completion", done_irq, 1);
    tick(3);
    #5;
    check("R6", "irq held until ack", done_irq, 1);
    ack();

    // flag clear (R5)
    @(posedge clk); q_clr = 3'b010;
    tick(2);
    #5;
    check("R5", "flag cleared", stall_flag, 3'b100);

    // dirty upper bits (R7)
    setup(32'h4000, 32'h0003_0004);
    go(0);
    tick(2);
    #5;
    check("R7", "word wiped", qwc_q, 0);
    check("R7", "idle after dirty start", busy, 0);
    check("R7", "irq after dirty start", done_irq, 1);
    check("R7", "FIFO untouched", fifo_q.size(), 2);
    ack();

    // zero count (R8), leave irq pending for R9
    setup(32'h5000, 32'd0);
    go(0);
    tick(1);
    #5;
    check("R8", "irq on zero count", done_irq, 1);
    check("R8", "idle on zero count", busy, 0);

    // start while irq pending (R9), not a stall source (R4)
    q_src = 0; q_dst = 1;
    setup(32'h2000, 32'd2);
    go(0);
    tick(8);
    #5;
    check("R9", "no move while irq pending", qwc_q, 32'd2);
    check("R9", "busy while blocked", busy, 1);
    ack();
    wait_idle();
    #5;
    check("R9", "resumed after ack", madr_q, 32'h2020);
    check("R4", "stall addr held when not source", stall_addr, 32'h1050);
    check("R5", "no flag when not source", stall_flag, 3'b100);
    ack();

    // tag transfer refused (R10)
    push(1);
    setup(32'h3000, 32'd1);
    go(1);
    tick(4);
    #5;
    check("R10", "tag start ignored busy", busy, 0);
    check("R10", "tag start no irq", done_irq, 0);
    check("R10", "tag start count kept", qwc_q, 32'd1);

    // writes while busy are dropped (R11)
    q_src = 1; q_dst = 1;
    fifo_q.delete();
    setup(32'h6000, 32'd3);
    go(0);
    setup(32'h7777, 32'd9);
    #5;
    check("R11", "madr write ignored", madr_q, 32'h6000);
    check("R11", "qwc write ignored", qwc_q, 32'd3);
    push(3);
    wait_idle();
    #5;
    check("R4", "stall addr as source", stall_addr, 32'h6030);
    check("R5", "dest 1 flag", stall_flag, 3'b101);
    ack();
    tick(3);
    wrap_up();
  end

endmodule